// File: doc/BRIEF.md
# I2C Client Address Matcher

This block sits behind the byte receiver of an I2C client. It looks at the first address byte after each Start or Restart, or the first two in 10-bit addressing, and decides whether the device is being selected. It returns an ACK or NACK decision for each byte it judges. On a full match it raises a level flag showing the client is active and a one-cycle address-interrupt pulse.

Four programmable 8-bit address registers are reused according to the addressing mode. They can serve as four plain 7-bit addresses, or as two 7-bit address/mask pairs. They can also serve as two 10-bit addresses, or as one 10-bit address with a 10-bit mask. Matched address bytes go either to two dedicated address buffers or to the shared receive buffer, chosen by a buffer-disable control. In 10-bit addressing with the address buffers disabled, the low address byte is held back until software has read the high byte out of the receive buffer.

Top module: `i2c_addr_match`

## Requirements
- R1: With `cfg_mode`=0 (7-bit), bits [7:1] of the first byte after a Start are compared with bits [7:1] of each of the four registers. Register i is `adr_regs[8*i+7:8*i]`. Bit 0 (R/W) is not compared. If any register is equal, `ack_valid`=1 and `ack`=1 one cycle after the byte strobe. Otherwise `ack_valid`=1 and `ack`=0.
- R2: With `cfg_mode`=1 (7-bit masked), register 0 is an address masked by register 1, and register 2 is an address masked by register 3. A mask bit of 1 makes that address bit a don't-care. Bit 0 is not compared. A match against either pair gives an ACK.
- R3: A full address match sets `client_active`, which stays set until the next Start or reset. It also pulses `addr_irq` for one cycle, in the same cycle as the ACK.
- R4: A NACKed byte writes no buffer and raises no flag. Once a decision is reached, whether match or mismatch, further bytes produce no `ack_valid` and no writes until the next Start.
- R5: A matched 7-bit byte is written whole, including R/W. With `cfg_bufdis`=0 it goes to address buffer 0 (`adb0_we`/`adb0_data`) and address buffer 1 is not written. With `cfg_bufdis`=1 it goes to the receive buffer (`rxb_we`/`rxb_data`).
- R6: With `cfg_mode`=2 (10-bit), bits [7:1] of the first byte are compared with bits [7:1] of register 1 and of register 3. All seven bits are compared, and no fixed prefix is enforced. On a match the byte is ACKed and written to address buffer 1, or to the receive buffer when `cfg_bufdis`=1. No flag is raised yet.
- R7: In 10-bit mode the second byte is compared in all 8 bits against register 0 if register 1 matched, or against register 2 if register 3 matched. On a match it is ACKed, written to address buffer 0 or to the receive buffer, and the flags of R3 are raised. Otherwise it is NACKed.
- R8: With `cfg_mode`=3 (10-bit masked), bits [7:1] of the upper byte are compared with register 1 masked by register 3. All 8 bits of the lower byte are compared with register 0 masked by register 2. The acknowledge, routing and flags follow R6 and R7.
- R9: In 10-bit mode with `cfg_bufdis`=1, the matched low byte goes to the receive buffer only once the high byte has been read. If `rxb_read` has pulsed since the high byte was written, the low byte is written together with its ACK. Otherwise the write is deferred and occurs one cycle after the next `rxb_read` pulse.
- R10: `start_det` returns matching to the first-byte state and clears `client_active`. It also discards a deferred low-byte write. A byte strobed in the same cycle as `start_det` is ignored. After reset, bytes are ignored until the first Start.
- R11: During and after a synchronous reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 7-bit, 1 7-bit masked, 2 10-bit, 3 10-bit masked |
| cfg_bufdis | input | 1 | 1 routes matched bytes to the receive buffer |
| adr_regs | input | 32 | Four address registers, register i at bits [8i+7:8i] |
| start_det | input | 1 | Start or Restart seen on the bus |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rxb_read | input | 1 | Software read of the receive buffer |
| ack_valid | output | 1 | A byte was judged this cycle |
| ack | output | 1 | 1 ACK, 0 NACK (valid with ack_valid) |
| adb0_we | output | 1 | Address buffer 0 write strobe |
| adb0_data | output | 8 | Address buffer 0 write data |
| adb1_we | output | 1 | Address buffer 1 write strobe |
| adb1_data | output | 8 | Address buffer 1 write data |
| rxb_we | output | 1 | Receive buffer write strobe |
| rxb_data | output | 8 | Receive buffer write data |
| client_active | output | 1 | Device addressed since last Start |
| addr_irq | output | 1 | One-cycle address-match interrupt pulse |

## Verification
Suppose the sequencer sits in the wrong state or remembers the wrong register pair. This shows on `ack_valid` and `ack` in the cycle after the next byte strobe, as a missing judgement, an extra one or the wrong decision. An error in the deferred-write state of the receive-buffer path shows only one cycle after the next `rxb_read`, as a missing, duplicated or stale `rxb_we`. A stale active flag stays visible on `client_active` until a Start clears it.

// File: rtl/iam_pkg.sv
package iam_pkg;
  typedef enum logic [1:0] {
    MODE_7   = 2'd0,
    MODE_7M  = 2'd1,
    MODE_10  = 2'd2,
    MODE_10M = 2'd3
  } iam_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_LOW   = 2'd2
  } iam_state_e;
endpackage

// File: rtl/iam_compare.sv
module iam_compare #(
  parameter int DW   = 8,
  parameter int NREG = 4
) (
  input  logic [NREG*DW-1:0]  regs,
  input  logic [DW-1:0]       byte_in,
  output logic                hit7,
  output logic                hit7m,
  output logic [NREG/2-1:0]   hi10,
  output logic [NREG/2-1:0]   lo10,
  output logic                hi10m,
  output logic                lo10m
);
  localparam int NPAIR = NREG / 2;

  logic [NREG-1:0]  eq7;
  logic [NPAIR-1:0] meq7;
  logic [NPAIR-1:0] spare_unused;

  // plain 7-bit comparison against every register
  for (genvar i = 0; i < NREG; i++) begin : g_plain
    assign eq7[i] = (byte_in[DW-1:1] == regs[i*DW+1 +: DW-1]);
  end

  // register pairs: even = address / low byte, odd = mask / high byte
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [DW-1:0] even_r, odd_r;
    assign even_r  = regs[(2*p)*DW +: DW];
    assign odd_r   = regs[(2*p+1)*DW +: DW];
    assign meq7[p] = (((byte_in[DW-1:1] ^ even_r[DW-1:1]) & ~odd_r[DW-1:1]) == '0);
    assign hi10[p] = (byte_in[DW-1:1] == odd_r[DW-1:1]);
    assign lo10[p] = (byte_in == even_r);
    assign spare_unused[p] = odd_r[0];
  end

  assign hit7  = |eq7;
  assign hit7m = |meq7;

  // masked 10-bit: regs 0/1 address, regs 2/3 mask
  logic [DW-1:0] r0, r1, r2, r3;
  assign r0 = regs[0*DW +: DW];
  assign r1 = regs[1*DW +: DW];
  assign r2 = regs[2*DW +: DW];
  assign r3 = regs[3*DW +: DW];

  assign hi10m = (((byte_in[DW-1:1] ^ r1[DW-1:1]) & ~r3[DW-1:1]) == '0);
  assign lo10m = (((byte_in ^ r0) & ~r2) == '0);
endmodule

// File: rtl/iam_seq.sv
module iam_seq
  import iam_pkg::*;
#(
  parameter int NPAIR = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic             start_det,
  input  logic             rx_valid,
  input  logic             hit7,
  input  logic             hit7m,
  input  logic [NPAIR-1:0] hi10,
  input  logic [NPAIR-1:0] lo10,
  input  logic             hi10m,
  input  logic             lo10m,
  output logic             ev_adr7,
  output logic             ev_hi,
  output logic             ev_lo,
  output logic             ack_valid,
  output logic             ack,
  output logic             client_active,
  output logic             addr_irq
);
  iam_state_e       state_q;
  logic [NPAIR-1:0] pair_q;
  logic             take, judge;

  assign take  = rx_valid && !start_det;
  assign judge = take && (state_q != ST_IDLE);

  always_comb begin
    ev_adr7 = 1'b0;
    ev_hi   = 1'b0;
    ev_lo   = 1'b0;
    if (take && state_q == ST_FIRST) begin
      case (cfg_mode)
        MODE_7:   ev_adr7 = hit7;
        MODE_7M:  ev_adr7 = hit7m;
        MODE_10:  ev_hi   = |hi10;
        default:  ev_hi   = hi10m;
      endcase
    end else if (take && state_q == ST_LOW) begin
      if (cfg_mode == MODE_10) ev_lo = |(lo10 & pair_q);
      else                     ev_lo = lo10m;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      pair_q        <= '0;
      ack_valid     <= 1'b0;
      ack           <= 1'b0;
      client_active <= 1'b0;
      addr_irq      <= 1'b0;
    end else begin
      ack_valid <= judge;
      ack       <= ev_adr7 | ev_hi | ev_lo;
      addr_irq  <= ev_adr7 | ev_lo;
      if (start_det) begin
        state_q       <= ST_FIRST;
        client_active <= 1'b0;
      end else if (judge) begin
        state_q <= ev_hi ? ST_LOW : ST_IDLE;
        if (ev_hi) pair_q <= hi10;
        if (ev_adr7 || ev_lo) client_active <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/iam_route.sv
module iam_route #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_bufdis,
  input  logic          start_det,
  input  logic          rxb_read,
  input  logic [DW-1:0] byte_in,
  input  logic          ev_adr7,
  input  logic          ev_hi,
  input  logic          ev_lo,
  output logic          adb0_we,
  output logic [DW-1:0] adb0_data,
  output logic          adb1_we,
  output logic [DW-1:0] adb1_data,
  output logic          rxb_we,
  output logic [DW-1:0] rxb_data
);
  logic          unread_q;
  logic          pend_q;
  logic [DW-1:0] pend_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      adb0_we   <= 1'b0;
      adb1_we   <= 1'b0;
      rxb_we    <= 1'b0;
      adb0_data <= '0;
      adb1_data <= '0;
      rxb_data  <= '0;
      unread_q  <= 1'b0;
      pend_q    <= 1'b0;
      pend_d    <= '0;
    end else begin
      adb0_we <= 1'b0;
      adb1_we <= 1'b0;
      rxb_we  <= 1'b0;
      if (start_det) begin
        pend_q   <= 1'b0;
        unread_q <= 1'b0;
      end else begin
        if (rxb_read) unread_q <= 1'b0;
        if (rxb_read && pend_q) begin
          rxb_we   <= 1'b1;
          rxb_data <= pend_d;
          pend_q   <= 1'b0;
        end
        if (ev_adr7) begin
          if (cfg_bufdis) begin rxb_we  <= 1'b1; rxb_data  <= byte_in; end
          else            begin adb0_we <= 1'b1; adb0_data <= byte_in; end
        end
        if (ev_hi) begin
          if (cfg_bufdis) begin
            rxb_we   <= 1'b1;
            rxb_data <= byte_in;
            unread_q <= 1'b1;
          end else begin
            adb1_we   <= 1'b1;
            adb1_data <= byte_in;
          end
        end
        if (ev_lo) begin
          if (!cfg_bufdis) begin
            adb0_we   <= 1'b1;
            adb0_data <= byte_in;
          end else if (!unread_q || rxb_read) begin
            rxb_we   <= 1'b1;
            rxb_data <= byte_in;
          end else begin
            pend_q <= 1'b1;
            pend_d <= byte_in;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int DW   = 8,
  parameter int NREG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_bufdis,
  input  logic [NREG*DW-1:0] adr_regs,
  input  logic             start_det,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_byte,
  input  logic             rxb_read,
  output logic             ack_valid,
  output logic             ack,
  output logic             adb0_we,
  output logic [DW-1:0]    adb0_data,
  output logic             adb1_we,
  output logic [DW-1:0]    adb1_data,
  output logic             rxb_we,
  output logic [DW-1:0]    rxb_data,
  output logic             client_active,
  output logic             addr_irq
);
  localparam int NPAIR = NREG / 2;

  logic             hit7, hit7m, hi10m, lo10m;
  logic [NPAIR-1:0] hi10, lo10;
  logic             ev_adr7, ev_hi, ev_lo;

  iam_compare #(.DW(DW), .NREG(NREG)) u_cmp (
    .regs    (adr_regs),
    .byte_in (rx_byte),
    .hit7    (hit7),
    .hit7m   (hit7m),
    .hi10    (hi10),
    .lo10    (lo10),
    .hi10m   (hi10m),
    .lo10m   (lo10m)
  );

  iam_seq #(.NPAIR(NPAIR)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .cfg_mode      (cfg_mode),
    .start_det     (start_det),
    .rx_valid      (rx_valid),
    .hit7          (hit7),
    .hit7m         (hit7m),
    .hi10          (hi10),
    .lo10          (lo10),
    .hi10m         (hi10m),
    .lo10m         (lo10m),
    .ev_adr7       (ev_adr7),
    .ev_hi         (ev_hi),
    .ev_lo         (ev_lo),
    .ack_valid     (ack_valid),
    .ack           (ack),
    .client_active (client_active),
    .addr_irq      (addr_irq)
  );

  iam_route #(.DW(DW)) u_route (
    .clk        (clk),
    .rst        (rst),
    .cfg_bufdis (cfg_bufdis),
    .start_det  (start_det),
    .rxb_read   (rxb_read),
    .byte_in    (rx_byte),
    .ev_adr7    (ev_adr7),
    .ev_hi      (ev_hi),
    .ev_lo      (ev_lo),
    .adb0_we    (adb0_we),
    .adb0_data  (adb0_data),
    .adb1_we    (adb1_we),
    .adb1_data  (adb1_data),
    .rxb_we     (rxb_we),
    .rxb_data   (rxb_data)
  );
endmodule

// File: rtl/iam_checker.sv
module iam_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_mode,
  input logic       cfg_bufdis,
  input logic       start_det,
  input logic       rx_valid,
  input logic       rxb_read,
  input logic       ack_valid,
  input logic       ack,
  input logic       adb0_we,
  input logic       adb1_we,
  input logic       rxb_we,
  input logic       client_active,
  input logic       addr_irq
);
  // R1
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> ($past(rx_valid) && !$past(start_det)));

  // R3
  irq_with_active_chk: assert property (@(posedge clk) disable iff (rst)
    addr_irq |-> (client_active && ack && ack_valid));

  // R4
  nack_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !ack) |-> (!adb0_we && !adb1_we && !rxb_we && !addr_irq));

  // R5
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({adb0_we, adb1_we, rxb_we}));

  // R6
  adb1_ten_bit_chk: assert property (@(posedge clk) disable iff (rst)
    adb1_we |-> ($past(cfg_mode == 2'd2 || cfg_mode == 2'd3) && !$past(cfg_bufdis) && !addr_irq));

  // R9
  deferred_rxb_chk: assert property (@(posedge clk) disable iff (rst)
    (rxb_we && !ack_valid) |-> $past(rxb_read));

  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!client_active && !ack_valid));
endmodule

bind i2c_addr_match iam_checker u_chk (.*);

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_bufdis = 1'b0;
  logic [31:0] adr_regs = '0;
  logic        start_det = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rxb_read = 1'b0;
  logic        ack_valid, ack, adb0_we, adb1_we, rxb_we, client_active, addr_irq;
  logic [7:0]  adb0_data, adb1_data, rxb_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_addr_match u0 (.*);

  // ---------------- behavioural reference model ----------------
  int       m_state;
  bit [1:0] m_pair;
  bit       m_unread, m_pend;
  bit [7:0] m_pendd;
  bit e_ackv, e_ack, e_act, e_irq, e_a0we, e_a1we, e_rwe;
  bit [7:0] e_a0d, e_a1d, e_rd;

  function automatic bit [7:0] rg(input int i);
    return adr_regs[i*8 +: 8];
  endfunction

  function automatic bit up7(input bit [7:0] b, input bit [7:0] a, input bit [7:0] m);
    return ((((b ^ a) & ~m) >> 1) == 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_pair = 0; m_unread = 0; m_pend = 0; m_pendd = 0;
      e_ackv = 0; e_ack = 0; e_act = 0; e_irq = 0;
      e_a0we = 0; e_a1we = 0; e_rwe = 0; e_a0d = 0; e_a1d = 0; e_rd = 0;
    end else begin
      bit ok;
      e_ackv = 0; e_ack = 0; e_irq = 0; e_a0we = 0; e_a1we = 0; e_rwe = 0;
      if (start_det) begin
        m_state = 1; e_act = 0; m_pend = 0; m_unread = 0;
      end else begin
        if (rxb_read && m_pend) begin e_rwe = 1; e_rd = m_pendd; m_pend = 0; end
        if (rxb_read) m_unread = 0;
        if (rx_valid && m_state != 0) begin
          ok = 0;
          e_ackv = 1;
          if (m_state == 1 && cfg_mode < 2) begin
            if (cfg_mode == 0) begin
              for (int i = 0; i < 4; i++) if (up7(rx_byte, rg(i), 8'h00)) ok = 1;
            end else begin
              if (up7(rx_byte, rg(0), rg(1)) || up7(rx_byte, rg(2), rg(3))) ok = 1;
            end
            if (ok) begin
              e_act = 1; e_irq = 1;
              if (cfg_bufdis) begin e_rwe = 1; e_rd = rx_byte; end
              else begin e_a0we = 1; e_a0d = rx_byte; end
            end
            m_state = 0;
          end else if (m_state == 1) begin
            if (cfg_mode == 2) begin
              m_pair[0] = up7(rx_byte, rg(1), 8'h00);
              m_pair[1] = up7(rx_byte, rg(3), 8'h00);
              ok = m_pair != 0;
            end else begin
              ok = up7(rx_byte, rg(1), rg(3));
            end
            if (ok) begin
              m_state = 2;
              if (cfg_bufdis) begin e_rwe = 1; e_rd = rx_byte; m_unread = 1; end
              else begin e_a1we = 1; e_a1d = rx_byte; end
            end else m_state = 0;
          end else begin
            if (cfg_mode == 2)
              ok = (m_pair[0] && rx_byte == rg(0)) || (m_pair[1] && rx_byte == rg(2));
            else
              ok = ((rx_byte ^ rg(0)) & ~rg(2)) == 0;
            if (ok) begin
              e_act = 1; e_irq = 1;
              if (!cfg_bufdis) begin e_a0we = 1; e_a0d = rx_byte; end
              else if (!m_unread) begin e_rwe = 1; e_rd = rx_byte; end
              else begin m_pend = 1; m_pendd = rx_byte; end
            end
            m_state = 0;
          end
          e_ack = ok;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [30:0] act, exp;
      act = {ack_valid, ack, adb0_we, adb1_we, rxb_we, client_active, addr_irq,
             adb0_data, adb1_data, rxb_data};
      exp = {e_ackv, e_ack, e_a0we, e_a1we, e_rwe, e_act, e_irq, e_a0d, e_a1d, e_rd};
      tests++;
      if (act !== exp) begin
        fails++;
        $display("FAIL model(R1,R3,R5,R9) t=%0t actual=%h expected=%h", $time, act, exp);
      end
    end
  end

  // ---------------- directed checks ----------------
  function automatic logic [6:0] flags();
    return {ack_valid, ack, adb0_we, adb1_we, rxb_we, client_active, addr_irq};
  endfunction

  task automatic chk(input string tag, input logic [7:0] a, input logic [7:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic start();
    start_det = 1'b1;
    @(negedge clk);
    start_det = 1'b0;
  endtask

  task automatic rdrx();
    rxb_read = 1'b1;
    @(negedge clk);
    rxb_read = 1'b0;
  endtask

  task automatic setr(input logic [7:0] r0, r1, r2, r3);
    adr_regs = {r3, r2, r1, r0};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 flags", {1'b0, flags()}, 8'h00);
    chk("R11 data", adb0_data | adb1_data | rxb_data, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 after", {1'b0, flags()}, 8'h00);

    // plain 7-bit
    setr(8'h50, 8'h62, 8'h7E, 8'hA4);
    send(8'h50);
    chk("R10 no start", {1'b0, flags()}, 8'h00);
    start();
    send(8'h63);
    chk("R1 match", {1'b0, flags()}, 8'b0111_0011);
    chk("R5 adb0 data", adb0_data, 8'h63);
    send(8'h50);
    chk("R4 after match", {1'b0, flags()}, 8'b0000_0010);
    start();
    chk("R10 clear", {1'b0, flags()}, 8'h00);
    send(8'h44);
    chk("R4 nack", {1'b0, flags()}, 8'b0100_0000);
    send(8'h50);
    chk("R4 ignored", {1'b0, flags()}, 8'h00);
    cfg_bufdis = 1'b1;
    start();
    send(8'hA5);
    chk("R5 rxb", {1'b0, flags()}, 8'b0110_0111);
    chk("R5 rxb data", rxb_data, 8'hA5);

    // masked 7-bit
    cfg_bufdis = 1'b0; cfg_mode = 2'd1;
    setr(8'h50, 8'h06, 8'h80, 8'h00);
    start(); send(8'h56);
    chk("R2 masked hit", {1'b0, flags()}, 8'b0111_0011);
    start(); send(8'h58);
    chk("R2 masked miss", {1'b0, flags()}, 8'b0100_0000);
    start(); send(8'h81);
    chk("R2 pair1", {1'b0, flags()}, 8'b0111_0011);

    // 10-bit
    cfg_mode = 2'd2;
    setr(8'h34, 8'hF2, 8'h99, 8'hF6);
    start(); send(8'hF3);
    chk("R6 upper", {1'b0, flags()}, 8'b0110_1000);
    chk("R6 adb1 data", adb1_data, 8'hF3);
    send(8'h34);
    chk("R7 lower", {1'b0, flags()}, 8'b0111_0011);
    chk("R7 adb0 data", adb0_data, 8'h34);
    start(); send(8'hF7); send(8'h34);
    chk("R7 cross pair", {1'b0, flags()}, 8'b0100_0000);
    start(); send(8'hF7); send(8'h99);
    chk("R7 pair1", {1'b0, flags()}, 8'b0111_0011);
    setr(8'h34, 8'h12, 8'h99, 8'hF6);
    start(); send(8'h12);
    chk("R6 no prefix", {1'b0, flags()}, 8'b0110_1000);

    // masked 10-bit
    cfg_mode = 2'd3;
    setr(8'h10, 8'hF4, 8'h0F, 8'h02);
    start(); send(8'hF6);
    chk("R8 upper", {1'b0, flags()}, 8'b0110_1000);
    send(8'h1B);
    chk("R8 lower", {1'b0, flags()}, 8'b0111_0011);
    start(); send(8'hF4); send(8'h30);
    chk("R8 lower miss", {1'b0, flags()}, 8'b0100_0000);
    start(); send(8'hF0);
    chk("R8 upper miss", {1'b0, flags()}, 8'b0100_0000);

    // 10-bit through the receive buffer
    cfg_mode = 2'd2; cfg_bufdis = 1'b1;
    setr(8'h34, 8'hF2, 8'h99, 8'hF6);
    start(); send(8'hF2);
    chk("R9 upper rxb", {1'b0, flags()}, 8'b0110_0100);
    send(8'h34);
    chk("R9 deferred", {1'b0, flags()}, 8'b0110_0011);
    @(negedge clk);
    chk("R9 still held", {1'b0, flags()}, 8'b0000_0010);
    rdrx();
    chk("R9 release", {1'b0, flags()}, 8'b0000_0110);
    chk("R9 data", rxb_data, 8'h34);
    rdrx();
    chk("R9 once", {1'b0, flags()}, 8'b0000_0010);
    start(); send(8'hF2); rdrx(); send(8'h34);
    chk("R9 direct", {1'b0, flags()}, 8'b0110_0111);
    start(); send(8'hF2); send(8'h34); start();
    chk("R10 cancel", {1'b0, flags()}, 8'h00);
    rdrx();
    chk("R10 discarded", {1'b0, flags()}, 8'h00);

    // start together with a byte
    cfg_mode = 2'd0; cfg_bufdis = 1'b0;
    setr(8'h50, 8'h62, 8'h7E, 8'hA4);
    start_det = 1'b1; rx_valid = 1'b1; rx_byte = 8'h63;
    @(negedge clk);
    start_det = 1'b0; rx_valid = 1'b0;
    chk("R10 same cycle", {1'b0, flags()}, 8'h00);
    send(8'h63);
    chk("R10 then match", {1'b0, flags()}, 8'b0111_0011);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule